// File: doc/BRIEF.md
# Per-Warp Instruction Buffer and Hazard-Checked Issue

This block sits between instruction decode and the execute stage of a core that interleaves several warps. Every decoded instruction arrives with a warp index, a destination register, two source registers and an opaque operation field. The block places it in a small first-in first-out buffer that belongs to that warp. Each warp has its own buffer, so a warp that cannot make progress only stalls its own instruction stream.

In every cycle the block looks at the head of each warp buffer. It drops any head whose registers are still held by an older instruction of the same warp, and offers the first remaining head in ascending warp order on a valid/ready issue port. When an instruction is accepted, its destination register is marked busy for its warp in a register scoreboard. A commit port clears that mark again when the result is written back.

An offer that has not been accepted stays fixed until the downstream stage takes it. A lower-numbered warp that becomes eligible in the meantime does not replace it.

Top module: `ibi_issue_unit`

## Requirements
- R1: `dec_ready` is high exactly when the buffer of the warp on `dec_warp` holds fewer than `IBUF_DEPTH` entries. While `dec_valid` is high and `dec_ready` is low, the instruction waits and is not lost. It enters the buffer once space frees.
- R2: Instructions of one warp leave the block in the order in which they entered.
- R3: When no offer is pending from an earlier cycle, the issue port presents the head of the lowest-numbered warp whose buffer is non-empty and whose head is free of hazards. Empty buffers are skipped.
- R4: A head is blocked while its warp's scoreboard marks any of its source 1, source 2 or destination registers as busy. The scan then moves on to the next warp, and `iss_valid` is low if no head is eligible.
- R5: Busy marks are kept separately for each warp. A register that is busy in one warp never blocks an instruction of another warp.
- R6: An issue counts only when `iss_valid` and `iss_ready` are both high. At most one issue takes place per cycle. The issued destination register becomes busy for its warp from the next cycle.
- R7: A pulse on `cmt_valid` clears the busy mark of register `cmt_rd` in warp `cmt_warp` from the next cycle.
- R8: If a commit clears the same warp and register that an issue reserves in the same cycle, the register remains busy.
- R9: While `iss_valid` is high and `iss_ready` is low, the next cycle presents the same offer: the same warp, registers and operation, with `iss_valid` still high.
- R10: After reset every buffer is empty, no register is busy, `iss_valid` is low and `dec_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | A decoded instruction is offered |
| dec_ready | output | 1 | The buffer of `dec_warp` has room |
| dec_warp | input | WID_W | Warp index of the decoded instruction |
| dec_rd | input | REG_W | Destination register |
| dec_rs1 | input | REG_W | First source register |
| dec_rs2 | input | REG_W | Second source register |
| dec_op | input | OP_W | Operation field, passed through unchanged |
| iss_valid | output | 1 | An instruction is offered for execution |
| iss_ready | input | 1 | The execute stage takes the offer |
| iss_warp | output | WID_W | Warp index of the offered instruction |
| iss_rd | output | REG_W | Destination register of the offer |
| iss_rs1 | output | REG_W | First source register of the offer |
| iss_rs2 | output | REG_W | Second source register of the offer |
| iss_op | output | OP_W | Operation field of the offer |
| cmt_valid | input | 1 | A result is committed |
| cmt_warp | input | WID_W | Warp of the committed instruction |
| cmt_rd | input | REG_W | Register whose busy mark is cleared |

## Verification
Some properties are checked on every cycle by the assertions:
- no buffer is pushed while full or popped while empty;
- an offer never carries a register that is busy in its warp;
- a pending offer holds still while `iss_ready` is low;
- a reservation and a release reach the scoreboard one cycle later, and a reservation beats a release of the same bit.

Other behaviour can only be shown by the bench scenarios:
- the order in which warps win;
- a stalled warp being bypassed by another;
- independence of busy marks across warps;
- in-order draining of a full buffer once a held decode input is admitted;
- a release that collides with a reservation, leaving the following dependent instruction blocked.

// File: rtl/ibi_pkg.sv
`timescale 1ns/1ps
package ibi_pkg;

    localparam int unsigned REG_COUNT = 32;
    localparam int unsigned REG_W     = $clog2(REG_COUNT);
    localparam int unsigned OP_W      = 8;

    typedef struct packed {
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [OP_W-1:0]  op;
    } instr_t;

    typedef logic [REG_COUNT-1:0] reg_mask_t;

    // true when any register named by the instruction is still held
    function automatic logic head_blocked(reg_mask_t mask, instr_t ins);
        return mask[ins.rs1] | mask[ins.rs2] | mask[ins.rd];
    endfunction

endpackage

// File: rtl/ibi_warp_fifo.sv
`timescale 1ns/1ps
module ibi_warp_fifo
    import ibi_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  instr_t push_data,
    input  logic   pop,
    output instr_t head,
    output logic   empty,
    output logic   full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    instr_t           slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] wrap_inc(logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty = (count_q == '0);
    assign full  = (count_q == FULL_CNT);
    assign head  = slots[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr_q] <= push_data;
                wr_ptr_q        <= wrap_inc(wr_ptr_q);
            end
            if (pop) begin
                rd_ptr_q <= wrap_inc(rd_ptr_q);
            end
            case ({push, pop})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    // R1: the decode side never writes into a full buffer
    p_no_overflow_r1: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R2: only an existing entry can leave
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/ibi_scoreboard.sv
`timescale 1ns/1ps
module ibi_scoreboard
    import ibi_pkg::*;
#(
    parameter int unsigned NUM_WARPS = 4,
    localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rsv_en,
    input  logic [WID_W-1:0]     rsv_warp,
    input  logic [REG_W-1:0]     rsv_reg,
    input  logic                 rel_en,
    input  logic [WID_W-1:0]     rel_warp,
    input  logic [REG_W-1:0]     rel_reg,
    output reg_mask_t            busy [NUM_WARPS]
);

    reg_mask_t busy_q [NUM_WARPS];
    reg_mask_t busy_d [NUM_WARPS];

    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            busy_d[w] = busy_q[w];
            if (rel_en && rel_warp == WID_W'(w)) begin
                busy_d[w][rel_reg] = 1'b0;
            end
            // applied last so that a reservation outranks a release
            if (rsv_en && rsv_warp == WID_W'(w)) begin
                busy_d[w][rsv_reg] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (rst) busy_q[w] <= '0;
            else     busy_q[w] <= busy_d[w];
        end
    end

    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            busy[w] = busy_q[w];
        end
    end

    logic same_bit;
    assign same_bit = rsv_en && rel_en && (rsv_warp == rel_warp) && (rsv_reg == rel_reg);

    // R6: a reservation is visible one cycle later
    p_reserve_r6: assert property (@(posedge clk) disable iff (rst)
        rsv_en |=> busy_q[$past(rsv_warp)][$past(rsv_reg)]);

    // R7: a release that does not collide clears the bit one cycle later
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (rel_en && !same_bit) |=> !busy_q[$past(rel_warp)][$past(rel_reg)]);

    // R8: a colliding release leaves the register busy
    p_collide_r8: assert property (@(posedge clk) disable iff (rst)
        same_bit |=> busy_q[$past(rel_warp)][$past(rel_reg)]);

endmodule

// File: rtl/ibi_pick.sv
`timescale 1ns/1ps
module ibi_pick #(
    parameter int unsigned NUM_WARPS = 4,
    localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] cand,
    input  logic                 hold,
    output logic                 gnt_vld,
    output logic [WID_W-1:0]     gnt_idx
);

    logic             lock_vld_q;
    logic [WID_W-1:0] lock_idx_q;
    logic             scan_vld;
    logic [WID_W-1:0] scan_idx;

    // fixed priority: lowest index wins
    always_comb begin
        scan_vld = 1'b0;
        scan_idx = '0;
        for (int i = 0; i < NUM_WARPS; i++) begin
            if (!scan_vld && cand[i]) begin
                scan_vld = 1'b1;
                scan_idx = WID_W'(i);
            end
        end
    end

    always_comb begin
        if (lock_vld_q) begin
            gnt_vld = cand[lock_idx_q];
            gnt_idx = lock_idx_q;
        end else begin
            gnt_vld = scan_vld;
            gnt_idx = scan_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_vld_q <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_vld_q <= hold;
            lock_idx_q <= gnt_idx;
        end
    end

    // R9: a locked warp stays eligible because busy bits only clear while it waits
    p_lock_eligible_r9: assert property (@(posedge clk) disable iff (rst)
        lock_vld_q |-> cand[lock_idx_q]);

endmodule

// File: rtl/ibi_issue_unit.sv
`timescale 1ns/1ps
module ibi_issue_unit
    import ibi_pkg::*;
#(
    parameter int unsigned NUM_WARPS  = 4,
    parameter int unsigned IBUF_DEPTH = 2,
    localparam int unsigned WID_W = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    output logic             dec_ready,
    input  logic [WID_W-1:0] dec_warp,
    input  logic [REG_W-1:0] dec_rd,
    input  logic [REG_W-1:0] dec_rs1,
    input  logic [REG_W-1:0] dec_rs2,
    input  logic [OP_W-1:0]  dec_op,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [WID_W-1:0] iss_warp,
    output logic [REG_W-1:0] iss_rd,
    output logic [REG_W-1:0] iss_rs1,
    output logic [REG_W-1:0] iss_rs2,
    output logic [OP_W-1:0]  iss_op,
    input  logic             cmt_valid,
    input  logic [WID_W-1:0] cmt_warp,
    input  logic [REG_W-1:0] cmt_rd
);

    instr_t               dec_ins;
    instr_t               head [NUM_WARPS];
    instr_t               pick_ins;
    reg_mask_t            busy [NUM_WARPS];
    logic [NUM_WARPS-1:0] buf_full, buf_empty, buf_push, buf_pop, cand;
    logic                 gnt_vld;
    logic [WID_W-1:0]     gnt_idx;
    logic                 accept;

    assign dec_ins   = '{rd: dec_rd, rs1: dec_rs1, rs2: dec_rs2, op: dec_op};
    assign dec_ready = !buf_full[dec_warp];
    assign accept    = gnt_vld && iss_ready;

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign buf_push[w] = dec_valid && (dec_warp == WID_W'(w)) && !buf_full[w];
        assign buf_pop[w]  = accept && (gnt_idx == WID_W'(w));
        assign cand[w]     = !buf_empty[w] && !head_blocked(busy[w], head[w]);

        ibi_warp_fifo #(.DEPTH(IBUF_DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (buf_push[w]),
            .push_data (dec_ins),
            .pop       (buf_pop[w]),
            .head      (head[w]),
            .empty     (buf_empty[w]),
            .full      (buf_full[w])
        );
    end

    ibi_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .cand    (cand),
        .hold    (gnt_vld && !iss_ready),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    ibi_scoreboard #(.NUM_WARPS(NUM_WARPS)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .rsv_en   (accept),
        .rsv_warp (gnt_idx),
        .rsv_reg  (pick_ins.rd),
        .rel_en   (cmt_valid),
        .rel_warp (cmt_warp),
        .rel_reg  (cmt_rd),
        .busy     (busy)
    );

    assign pick_ins  = head[gnt_idx];
    assign iss_valid = gnt_vld;
    assign iss_warp  = gnt_idx;
    assign iss_rd    = pick_ins.rd;
    assign iss_rs1   = pick_ins.rs1;
    assign iss_rs2   = pick_ins.rs2;
    assign iss_op    = pick_ins.op;

    // R4: an offer never names a register busy in its own warp
    p_offer_clean_r4: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> !(busy[iss_warp][iss_rs1] || busy[iss_warp][iss_rs2]
                        || busy[iss_warp][iss_rd]));

    // R9: a pending offer is held unchanged
    p_hold_offer_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_warp) && $stable(iss_rd)
                                       && $stable(iss_rs1) && $stable(iss_rs2) && $stable(iss_op)));

    // R10: the first cycle after reset offers nothing and accepts input
    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!iss_valid && dec_ready));

endmodule

// File: tb/tb_ibi_issue_unit.sv
`timescale 1ns/1ps
module tb_ibi_issue_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dec_valid = 1'b0;
    logic       dec_ready;
    logic [1:0] dec_warp = '0;
    logic [4:0] dec_rd = '0, dec_rs1 = '0, dec_rs2 = '0;
    logic [7:0] dec_op = '0;
    logic       iss_valid;
    logic       iss_ready = 1'b0;
    logic [1:0] iss_warp;
    logic [4:0] iss_rd, iss_rs1, iss_rs2;
    logic [7:0] iss_op;
    logic       cmt_valid = 1'b0;
    logic [1:0] cmt_warp = '0;
    logic [4:0] cmt_rd = '0;

    always #2.5 clk = ~clk;

    ibi_issue_unit #(.NUM_WARPS(4), .IBUF_DEPTH(2)) dut (
        .clk(clk), .rst(rst),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_warp(dec_warp),
        .dec_rd(dec_rd), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_op(dec_op),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_warp(iss_warp),
        .iss_rd(iss_rd), .iss_rs1(iss_rs1), .iss_rs2(iss_rs2), .iss_op(iss_op),
        .cmt_valid(cmt_valid), .cmt_warp(cmt_warp), .cmt_rd(cmt_rd)
    );

    typedef struct {
        logic [28:0] val;   // {warp, rd, rs1, rs2, op}
        string       req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_iss(input logic [1:0] w, input logic [4:0] rd, input logic [4:0] s1,
                              input logic [4:0] s2, input logic [7:0] op, input string req);
        exp_t e;
        e.val = {w, rd, s1, s2, op};
        e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor: every accepted issue is compared against the queue head
    always @(negedge clk) begin
        if (!rst && iss_valid && iss_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected issue", {iss_warp, iss_rd, iss_rs1, iss_rs2, iss_op}, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({iss_warp, iss_rd, iss_rs1, iss_rs2, iss_op} == e.val, e.req, "issued instr",
                    {iss_warp, iss_rd, iss_rs1, iss_rs2, iss_op}, e.val);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [1:0] w, input logic [4:0] rd, input logic [4:0] s1,
                        input logic [4:0] s2, input logic [7:0] op);
        @(posedge clk); #1;
        dec_valid = 1'b1; dec_warp = w; dec_rd = rd; dec_rs1 = s1; dec_rs2 = s2; dec_op = op;
        do @(negedge clk); while (!dec_ready);
        @(posedge clk); #1;
        dec_valid = 1'b0;
    endtask

    task automatic commit(input logic [1:0] w, input logic [4:0] r);
        @(posedge clk); #1;
        cmt_valid = 1'b1; cmt_warp = w; cmt_rd = r;
        @(posedge clk); #1;
        cmt_valid = 1'b0;
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, "pending expected issues", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog run did not end actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [4:0] rd_seen;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(1);
        // R10: reset state
        chk(iss_valid == 1'b0, "R10", "iss_valid after reset", iss_valid, 0);
        chk(dec_ready == 1'b1, "R10", "dec_ready after reset", dec_ready, 1);

        // basic issue, R6 accept
        iss_ready = 1'b1;
        expect_iss(2, 1, 3, 4, 8'h01, "R6");
        push(2, 1, 3, 4, 8'h01);
        idle(3);
        drained("R6");
        commit(2, 1);

        // read-after-write hazard, other warp bypasses (R4, R5), release (R7)
        expect_iss(0, 5, 1, 2, 8'h11, "R6");
        push(0, 5, 1, 2, 8'h11);
        idle(3);
        push(0, 6, 5, 3, 8'h12);
        idle(3);
        chk(iss_valid == 1'b0, "R4", "source hazard blocks head", iss_valid, 0);
        expect_iss(1, 5, 5, 5, 8'h13, "R5");
        push(1, 5, 5, 5, 8'h13);
        idle(3);
        chk(iss_valid == 1'b0, "R4", "warp0 still blocked after warp1 issue", iss_valid, 0);
        drained("R5");
        expect_iss(0, 6, 5, 3, 8'h12, "R7");
        commit(0, 5);
        idle(3);
        drained("R7");
        commit(0, 6);
        commit(1, 5);

        // destination hazard (R4)
        expect_iss(2, 7, 0, 0, 8'h21, "R6");
        push(2, 7, 0, 0, 8'h21);
        idle(3);
        push(2, 7, 0, 0, 8'h22);
        idle(3);
        chk(iss_valid == 1'b0, "R4", "destination hazard blocks head", iss_valid, 0);
        expect_iss(2, 7, 0, 0, 8'h22, "R7");
        commit(2, 7);
        idle(3);
        drained("R7");
        commit(2, 7);

        // priority and hold (R3, R9)
        iss_ready = 1'b0;
        push(3, 14, 0, 0, 8'h31);
        push(1, 15, 0, 0, 8'h32);
        push(0, 16, 0, 0, 8'h33);
        idle(1);
        chk(iss_valid && iss_warp == 2'd3, "R9", "held offer warp", iss_warp, 3);
        rd_seen = iss_rd;
        idle(2);
        chk(iss_valid && iss_warp == 2'd3 && iss_rd == rd_seen && iss_op == 8'h31,
            "R9", "offer stable while not ready", iss_op, 8'h31);
        expect_iss(3, 14, 0, 0, 8'h31, "R9");
        expect_iss(0, 16, 0, 0, 8'h33, "R3");
        expect_iss(1, 15, 0, 0, 8'h32, "R3");
        iss_ready = 1'b1;
        idle(4);
        drained("R3");
        commit(3, 14);
        commit(1, 15);
        commit(0, 16);

        // full buffer back-pressure and per-warp order (R1, R2)
        iss_ready = 1'b0;
        push(3, 17, 0, 0, 8'h41);
        push(3, 18, 0, 0, 8'h42);
        @(posedge clk); #1;
        dec_warp = 2'd1;
        #0.5;
        chk(dec_ready == 1'b1, "R1", "ready for warp with room", dec_ready, 1);
        dec_warp = 2'd3; dec_rd = 19; dec_rs1 = 0; dec_rs2 = 0; dec_op = 8'h43;
        #0.5;
        chk(dec_ready == 1'b0, "R1", "ready for full warp", dec_ready, 0);
        dec_valid = 1'b1;
        idle(2);
        chk(dec_ready == 1'b0, "R1", "held input stays waiting", dec_ready, 0);
        expect_iss(3, 17, 0, 0, 8'h41, "R2");
        expect_iss(3, 18, 0, 0, 8'h42, "R2");
        expect_iss(3, 19, 0, 0, 8'h43, "R1");
        iss_ready = 1'b1;
        do @(negedge clk); while (!dec_ready);
        @(posedge clk); #1;
        dec_valid = 1'b0;
        idle(4);
        drained("R2");
        commit(3, 17);
        commit(3, 18);
        commit(3, 19);

        // release colliding with reservation (R8)
        iss_ready = 1'b0;
        push(0, 9, 0, 0, 8'h51);
        idle(1);
        expect_iss(0, 9, 0, 0, 8'h51, "R8");
        cmt_valid = 1'b1; cmt_warp = 2'd0; cmt_rd = 5'd9;
        iss_ready = 1'b1;
        @(posedge clk); #1;
        cmt_valid = 1'b0;
        push(0, 13, 9, 0, 8'h52);
        idle(3);
        chk(iss_valid == 1'b0, "R8", "reserve outranks same-cycle release", iss_valid, 0);
        expect_iss(0, 13, 9, 0, 8'h52, "R7");
        commit(0, 9);
        idle(3);
        drained("R8");
        commit(0, 13);

        idle(2);
        drained("R2");
        finish_run();
    end

endmodule